// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs one complete I2C master transaction from a single command. A command gives the target address, a flag that selects 10-bit addressing, a write byte count and a read byte count. Once `cmd_go` is accepted, the sequencer waits for the bus to become free. It then steps a bit-level engine through the whole transaction: a START, the address phase, the write burst, an optional repeated START with a read burst, and a STOP.

The block does not generate SCL timing. Each step goes to the engine as an operation code (`bit_op`: 0 = START, 1 = STOP, 2 = write byte, 3 = read byte). The operation is held on `bit_valid` until the engine pulses `eng_done`.

Write bytes are taken from a valid/ready stream, one byte at a time, only when the next byte is needed. Received bytes leave on a second stream. Errors are collected in a five-bit vector that is held until the next accepted command:
- bit 0: target NACK
- bit 1: arbitration lost
- bit 2: bus error
- bit 3: receive overrun
- bit 4: bus-wait timeout

Top module: `i2c_txn_seq`

## Requirements
- R1: With 7-bit addressing, the byte written after each START is `{addr[6:0], rw}`, where rw is 0 for a write phase and 1 for a read phase.
- R2: With 10-bit addressing, a write-phase header is `{5'b11110, addr[9:8], 0}` followed by `addr[7:0]`. A read phase sends only the header `{5'b11110, addr[9:8], 1}` after a repeated START. A read-only 10-bit command first addresses the target in a write phase with no data.
- R3: When both counts are non-zero, all write bytes go out first, followed by a START with no STOP in between, and then a read-phase address.
- R4: Each read operation asks for ACK (`bit_nack`=0) except the last one of the burst, which asks for NACK. A one-byte read NACKs its only byte.
- R5: A STOP follows the last write byte when the read count is zero, and follows the final read byte. `done` is raised for one cycle after the STOP completes, and `err` is then 0.
- R6: A target NACK on any address or data byte sets err bit 0, skips the remaining bytes, issues a STOP and then pulses `done`.
- R7: No START is issued while `bus_busy` or `stop_pending` is high. If they stay high for `wait_limit` cycles, err bit 4 is set, `done` pulses, and no engine operation is issued.
- R8: `eng_arb_lost` sets err bit 1 and `eng_bus_err` sets err bit 2. In both cases the block returns to idle at once, issues no STOP and pulses `done`.
- R9: `tx_ready` is high only while the next write byte is needed. While it waits for `tx_valid`, no engine operation is issued. The stream is never read beyond the write count.
- R10: `done` lasts exactly one cycle. `err` keeps its value until the next accepted command, and `cmd_ready` is high only when idle.
- R11: If a read byte arrives while the previous received byte is still unconsumed (`rx_valid` high, `rx_ready` low), err bit 3 is set and the transaction still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_go | input | 1 | Start a transaction (taken when cmd_ready) |
| cmd_ready | output | 1 | Sequencer idle |
| cmd_addr | input | 10 | Target address |
| cmd_ten | input | 1 | 1 = 10-bit addressing |
| cmd_wr_cnt | input | CNT_W | Bytes to write |
| cmd_rd_cnt | input | CNT_W | Bytes to read |
| wait_limit | input | TMO_W | Cycles allowed for the bus to become free |
| tx_valid | input | 1 | Write byte available |
| tx_ready | output | 1 | Write byte requested |
| tx_data | input | 8 | Write byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Received byte consumed |
| rx_data | output | 8 | Received byte |
| bus_busy | input | 1 | Bus busy indication |
| stop_pending | input | 1 | A STOP is still being generated |
| bit_valid | output | 1 | Engine operation requested |
| bit_op | output | 2 | Engine operation code |
| bit_wdata | output | 8 | Byte to write |
| bit_nack | output | 1 | NACK the byte being read |
| eng_done | input | 1 | Engine finished the operation |
| eng_rdata | input | 8 | Byte read by the engine |
| eng_nack | input | 1 | Target did not acknowledge the written byte |
| eng_arb_lost | input | 1 | Arbitration lost |
| eng_bus_err | input | 1 | Misplaced START/STOP detected |
| done | output | 1 | Transaction ended (one cycle) |
| err | output | 5 | Error bits, held until next command |

## Verification
The bench builds the block with CNT_W=3 and TMO_W=8. The three-bit counts make a seven-byte burst the full range of the byte counters, so wrap and the last-byte decision are tested at the counter's top value. The eight-bit wait limit lets the bus-busy timeout and a late bus release both happen within a few dozen cycles. A behavioural engine model compares every requested operation against a list derived from the requirements. It can inject NACKs, arbitration loss and bus errors at any chosen operation.

// File: rtl/i2c_seq_pkg.sv
// Shared definitions for the I2C transaction sequencer.
// Assumes: the engine decodes bit_op with the encoding below.
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } bit_op_t;

    localparam int ERR_W    = 5;
    localparam int ERR_NACK = 0;
    localparam int ERR_ARB  = 1;
    localparam int ERR_BUS  = 2;
    localparam int ERR_OVR  = 3;
    localparam int ERR_TMO  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT,
        ST_START,
        ST_HDR,
        ST_LOW,
        ST_FETCH,
        ST_WRITE,
        ST_READ,
        ST_STOP
    } seq_state_t;

endpackage

// File: rtl/i2c_seq_addr.sv
// Address byte builder.
// Produces either the first address byte (7-bit address with R/W, or the
// 10-bit header) or the low byte of a 10-bit address.
// Assumes: low_byte is only used with ten set.
module i2c_seq_addr (
    input  logic [9:0] addr,
    input  logic       ten,
    input  logic       rd,
    input  logic       low_byte,
    output logic [7:0] byte_out
);
    // select header form or low address byte
    always_comb begin
        if (low_byte)
            byte_out = addr[7:0];
        else if (ten)
            byte_out = {5'b11110, addr[9:8], rd};
        else
            byte_out = {addr[6:0], rd};
    end
endmodule

// File: rtl/i2c_seq_wait.sv
// Bus-free wait timer.
// While armed, it reports the bus free once both busy indications are low.
// It reports expiry once the wait has lasted limit cycles with the bus still busy.
// Assumes: arm stays high for the whole wait and drops afterwards.
module i2c_seq_wait #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             bus_busy,
    input  logic             stop_pending,
    input  logic [TMO_W-1:0] limit,
    output logic             free,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    assign free    = arm && !bus_busy && !stop_pending;
    assign expired = arm && !free && (cnt >= limit);

    // count cycles spent waiting, cleared when not armed
    always_ff @(posedge clk) begin
        if (!rst_n || !arm)
            cnt <= '0;
        else if (cnt != {TMO_W{1'b1}})
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_seq_rx.sv
// Receive output register.
// Holds one received byte until it is consumed.
// Flags an overrun when a new byte overwrites one that was not consumed.
// Assumes: load is a single-cycle strobe per received byte.
module i2c_seq_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       rx_ready,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       ovr
);
    assign ovr = load && rx_valid && !rx_ready;

    // capture new bytes, drop valid when consumed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else if (load) begin
            rx_valid <= 1'b1;
            rx_data  <= din;
        end else if (rx_ready) begin
            rx_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_txn_seq.sv
// I2C master transaction sequencer (top).
// Steps a bit-level engine through START, address, write burst, optional
// repeated START plus read burst, and STOP, for one command at a time.
// Assumes: the engine holds off on a new operation in the cycle after eng_done,
// and keeps SCL low while no operation is requested.
module i2c_txn_seq
    import i2c_seq_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_go,
    output logic             cmd_ready,
    input  logic [9:0]       cmd_addr,
    input  logic             cmd_ten,
    input  logic [CNT_W-1:0] cmd_wr_cnt,
    input  logic [CNT_W-1:0] cmd_rd_cnt,
    input  logic [TMO_W-1:0] wait_limit,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic [7:0]       tx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic [7:0]       rx_data,
    input  logic             bus_busy,
    input  logic             stop_pending,
    output logic             bit_valid,
    output logic [1:0]       bit_op,
    output logic [7:0]       bit_wdata,
    output logic             bit_nack,
    input  logic             eng_done,
    input  logic [7:0]       eng_rdata,
    input  logic             eng_nack,
    input  logic             eng_arb_lost,
    input  logic             eng_bus_err,
    output logic             done,
    output logic [ERR_W-1:0] err
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_state_t       state;
    logic [9:0]       addr_q;
    logic             ten_q;
    logic             rd_ph;
    logic [CNT_W-1:0] wleft;
    logic [CNT_W-1:0] rleft;
    logic [7:0]       wbyte;
    logic [7:0]       addr_byte;
    logic             bus_free;
    logic             bus_tmo;
    logic             rx_ovr;
    logic             active;
    logic             fault;
    logic             w_more;
    logic             rx_load;

    i2c_seq_addr u_addr (
        .addr     (addr_q),
        .ten      (ten_q),
        .rd       (rd_ph),
        .low_byte (state == ST_LOW),
        .byte_out (addr_byte)
    );

    i2c_seq_wait #(.TMO_W(TMO_W)) u_wait (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm          (state == ST_WAIT),
        .bus_busy     (bus_busy),
        .stop_pending (stop_pending),
        .limit        (wait_limit),
        .free         (bus_free),
        .expired      (bus_tmo)
    );

    i2c_seq_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rx_load),
        .din      (eng_rdata),
        .rx_ready (rx_ready),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .ovr      (rx_ovr)
    );

    // engine request decode from the current step
    always_comb begin
        active    = (state != ST_IDLE) && (state != ST_WAIT);
        fault     = active && (eng_arb_lost || eng_bus_err);
        bit_valid = active && (state != ST_FETCH);
        unique case (state)
            ST_START: bit_op = OP_START;
            ST_STOP:  bit_op = OP_STOP;
            ST_READ:  bit_op = OP_READ;
            default:  bit_op = OP_WRITE;
        endcase
        bit_wdata = (state == ST_WRITE) ? wbyte : addr_byte;
        bit_nack  = (state == ST_READ) && (rleft == ONE);
        w_more    = (state == ST_WRITE) ? (wleft > ONE) : (wleft != '0);
        rx_load   = (state == ST_READ) && eng_done && !fault;
        cmd_ready = (state == ST_IDLE);
        tx_ready  = (state == ST_FETCH);
    end

    // transaction step sequencing and error capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            ten_q  <= 1'b0;
            rd_ph  <= 1'b0;
            wleft  <= '0;
            rleft  <= '0;
            wbyte  <= '0;
            done   <= 1'b0;
            err    <= '0;
        end else begin
            done <= 1'b0;
            if (rx_ovr)
                err[ERR_OVR] <= 1'b1;
            if (fault) begin
                state <= ST_IDLE;
                done  <= 1'b1;
                if (eng_arb_lost) err[ERR_ARB] <= 1'b1;
                if (eng_bus_err)  err[ERR_BUS] <= 1'b1;
            end else begin
                unique case (state)
                    ST_IDLE: if (cmd_go) begin
                        addr_q <= cmd_addr;
                        ten_q  <= cmd_ten;
                        wleft  <= cmd_wr_cnt;
                        rleft  <= cmd_rd_cnt;
                        rd_ph  <= !cmd_ten && (cmd_wr_cnt == '0) && (cmd_rd_cnt != '0);
                        err    <= '0;
                        state  <= ST_WAIT;
                    end
                    ST_WAIT: if (bus_free) begin
                        state <= ST_START;
                    end else if (bus_tmo) begin
                        err[ERR_TMO] <= 1'b1;
                        done         <= 1'b1;
                        state        <= ST_IDLE;
                    end
                    ST_START: if (eng_done) state <= ST_HDR;
                    ST_FETCH: if (tx_valid) begin
                        wbyte <= tx_data;
                        state <= ST_WRITE;
                    end
                    ST_HDR, ST_LOW, ST_WRITE: if (eng_done) begin
                        if (state == ST_WRITE)
                            wleft <= wleft - ONE;
                        if (eng_nack) begin
                            err[ERR_NACK] <= 1'b1;
                            state         <= ST_STOP;
                        end else if (state == ST_HDR && rd_ph) begin
                            state <= ST_READ;
                        end else if (state == ST_HDR && ten_q) begin
                            state <= ST_LOW;
                        end else if (w_more) begin
                            state <= ST_FETCH;
                        end else if (rleft != '0) begin
                            rd_ph <= 1'b1;
                            state <= ST_START;
                        end else begin
                            state <= ST_STOP;
                        end
                    end
                    ST_READ: if (eng_done) begin
                        rleft <= rleft - ONE;
                        if (rleft == ONE) state <= ST_STOP;
                    end
                    ST_STOP: if (eng_done) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_txn_seq_chk.sv
// Protocol checker for the I2C transaction sequencer, bound to the top.
// Watches only the top-level ports.
module i2c_txn_seq_chk
    import i2c_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_ready,
    input logic       tx_ready,
    input logic       bit_valid,
    input logic [1:0] bit_op,
    input logic       bit_nack,
    input logic       eng_done,
    input logic       eng_arb_lost,
    input logic       eng_bus_err,
    input logic       bus_busy,
    input logic       stop_pending,
    input logic       done
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R10

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);  // R10

    AST_STALL_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !bit_valid);  // R9

    AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && (eng_arb_lost || eng_bus_err)) |=> !bit_valid);  // R8

    AST_START_ON_FREE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && bit_op == 2'(OP_START) && !$past(bit_valid))
            |-> $past(!bus_busy && !stop_pending));  // R7

    AST_NACK_BYTE_THEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && bit_op == 2'(OP_READ) && bit_nack && eng_done
            && !eng_arb_lost && !eng_bus_err)
            |=> (bit_valid && bit_op == 2'(OP_STOP)));  // R4
endmodule

bind i2c_txn_seq i2c_txn_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_ready    (cmd_ready),
    .tx_ready     (tx_ready),
    .bit_valid    (bit_valid),
    .bit_op       (bit_op),
    .bit_nack     (bit_nack),
    .eng_done     (eng_done),
    .eng_arb_lost (eng_arb_lost),
    .eng_bus_err  (eng_bus_err),
    .bus_busy     (bus_busy),
    .stop_pending (stop_pending),
    .done         (done)
);

// File: tb/i2c_txn_seq_test.sv
// Scoreboard bench: the driver builds the expected engine operations and
// received bytes; the engine model and rx monitor pop and compare them.
module i2c_txn_seq_test;
    localparam int CNT_W = 3;
    localparam int TMO_W = 8;
    localparam int ENG_LAT = 3;

    typedef struct {
        logic [1:0] op;
        logic [7:0] data;
        logic       nack;
    } ent_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_go = 1'b0;
    logic             cmd_ready;
    logic [9:0]       cmd_addr = '0;
    logic             cmd_ten = 1'b0;
    logic [CNT_W-1:0] cmd_wr_cnt = '0;
    logic [CNT_W-1:0] cmd_rd_cnt = '0;
    logic [TMO_W-1:0] wait_limit = 8'd100;
    logic             tx_valid = 1'b0;
    logic             tx_ready;
    logic [7:0]       tx_data = '0;
    logic             rx_valid;
    logic             rx_ready = 1'b1;
    logic [7:0]       rx_data;
    logic             bus_busy = 1'b0;
    logic             stop_pending = 1'b0;
    logic             bit_valid;
    logic [1:0]       bit_op;
    logic [7:0]       bit_wdata;
    logic             bit_nack;
    logic             eng_done = 1'b0;
    logic [7:0]       eng_rdata = '0;
    logic             eng_nack = 1'b0;
    logic             eng_arb_lost = 1'b0;
    logic             eng_bus_err = 1'b0;
    logic             done;
    logic [4:0]       err;

    int   n_checks = 0;
    int   n_fail = 0;
    ent_t exp_ops[$];
    logic [7:0] exp_rx[$];
    logic [7:0] tx_q[$];
    int   op_idx = 0;
    int   nack_at = -1;
    int   fault_at = -1;
    bit   fault_arb = 1'b0;
    int   tx_delay = 0;
    bit   rx_chk = 1'b1;
    string cur_tag = "R0";
    logic tx_fire = 1'b0;
    logic rx_fire = 1'b0;
    logic [7:0] rx_cap = '0;

    i2c_txn_seq #(.CNT_W(CNT_W), .TMO_W(TMO_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_ten(cmd_ten), .cmd_wr_cnt(cmd_wr_cnt),
        .cmd_rd_cnt(cmd_rd_cnt), .wait_limit(wait_limit),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .bus_busy(bus_busy), .stop_pending(stop_pending),
        .bit_valid(bit_valid), .bit_op(bit_op), .bit_wdata(bit_wdata),
        .bit_nack(bit_nack), .eng_done(eng_done), .eng_rdata(eng_rdata),
        .eng_nack(eng_nack), .eng_arb_lost(eng_arb_lost),
        .eng_bus_err(eng_bus_err), .done(done), .err(err)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] hdr(input logic [9:0] a, input bit ten, input bit rd);
        return ten ? {5'b11110, a[9:8], rd} : {a[6:0], rd};
    endfunction

    // handshakes happen at the edge; record them for the negedge processes
    always @(posedge clk) begin
        tx_fire <= tx_valid && tx_ready;
        rx_fire <= rx_valid && rx_ready;
        rx_cap  <= rx_data;
    end

    // transmit source: offers the next byte only after tx_delay requested cycles
    initial begin
        int wait_ct = 0;
        forever begin
            @(negedge clk);
            if (tx_fire && tx_q.size() > 0) begin
                void'(tx_q.pop_front());
                tx_valid = 1'b0;
            end
            if (tx_q.size() == 0) tx_valid = 1'b0;
            if (!tx_valid && tx_ready && tx_q.size() > 0) begin
                if (wait_ct < tx_delay) begin
                    check(!bit_valid, "R9 stall", bit_valid, 0);
                    wait_ct++;
                end else begin
                    tx_valid = 1'b1;
                    tx_data  = tx_q[0];
                    wait_ct  = 0;
                end
            end
        end
    end

    // receive monitor: compares delivered bytes with the expected queue
    initial forever begin
        @(negedge clk);
        if (rx_fire && rx_chk) begin
            if (exp_rx.size() == 0)
                check(1'b0, {cur_tag, " unexpected rx"}, rx_cap, 0);
            else begin
                logic [7:0] e;
                e = exp_rx.pop_front();
                check(rx_cap == e, {cur_tag, " rx byte"}, rx_cap, e);
            end
        end
    end

    // engine model: takes each requested operation and compares it with the scoreboard
    initial forever begin
        @(negedge clk);
        if (rst_n && bit_valid) begin
            logic [1:0] op;
            logic [7:0] d;
            logic       nk;
            op = bit_op;
            d  = bit_wdata;
            nk = bit_nack;
            if (exp_ops.size() == 0)
                check(1'b0, {cur_tag, " unexpected op"}, op, 0);
            else begin
                ent_t e;
                e = exp_ops.pop_front();
                check(op == e.op && (op != 2'd2 || d == e.data) && (op != 2'd3 || nk == e.nack),
                      {cur_tag, " op"}, {op, d, nk}, {e.op, e.data, e.nack});
            end
            repeat (ENG_LAT) @(negedge clk);
            if (op_idx == fault_at) begin
                if (fault_arb) eng_arb_lost = 1'b1;
                else           eng_bus_err  = 1'b1;
            end else begin
                eng_done  = 1'b1;
                eng_nack  = (op == 2'd2) && (op_idx == nack_at);
                eng_rdata = 8'h3C ^ 8'(op_idx);
            end
            op_idx++;
            @(negedge clk);
            eng_done = 1'b0; eng_nack = 1'b0; eng_arb_lost = 1'b0; eng_bus_err = 1'b0;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    int exp_err_g = 0;
    bit tx_chk_g = 1'b1;

    task automatic start_txn(input logic [9:0] a, input bit ten, input int w, input int r,
                             input int nk, input int ft, input bit arb, input int dly,
                             input int e_err, input bit rxc, input string tag);
        ent_t lst[$];
        bit rd_first;
        cur_tag = tag; exp_err_g = e_err; nack_at = nk; fault_at = ft; fault_arb = arb;
        tx_delay = dly; rx_chk = rxc; op_idx = 0;
        tx_chk_g = (nk < 0) && (ft < 0) && (e_err == 0);
        for (int i = 0; i < w; i++) tx_q.push_back(8'h90 + 8'(i));
        tx_q.push_back(8'hEE);
        if (e_err[4] == 1'b0) begin
            rd_first = !ten && w == 0 && r != 0;
            lst.push_back('{2'd0, 8'h00, 1'b0});
            lst.push_back('{2'd2, hdr(a, ten, rd_first), 1'b0});
            if (!rd_first) begin
                if (ten) lst.push_back('{2'd2, a[7:0], 1'b0});
                for (int i = 0; i < w; i++) lst.push_back('{2'd2, 8'h90 + 8'(i), 1'b0});
                if (r != 0) begin
                    lst.push_back('{2'd0, 8'h00, 1'b0});
                    lst.push_back('{2'd2, hdr(a, ten, 1'b1), 1'b0});
                end
            end
            for (int j = 0; j < r; j++) lst.push_back('{2'd3, 8'h00, j == r - 1});
            lst.push_back('{2'd1, 8'h00, 1'b0});
            if (nk >= 0) begin
                while (lst.size() > nk + 1) void'(lst.pop_back());
                lst.push_back('{2'd1, 8'h00, 1'b0});
            end
            if (ft >= 0)
                while (lst.size() > ft + 1) void'(lst.pop_back());
        end
        foreach (lst[p]) begin
            exp_ops.push_back(lst[p]);
            if (rxc && lst[p].op == 2'd3 && p != ft) exp_rx.push_back(8'h3C ^ 8'(p));
        end
        @(negedge clk);
        check(cmd_ready, {tag, " R10 ready"}, cmd_ready, 1);
        cmd_addr = a; cmd_ten = ten; cmd_wr_cnt = CNT_W'(w); cmd_rd_cnt = CNT_W'(r);
        cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
    endtask

    task automatic finish_txn();
        int guard = 0;
        while (!done && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        check(done == 1'b1, {cur_tag, " done"}, done, 1);
        check(err == 5'(exp_err_g), {cur_tag, " err"}, err, exp_err_g);
        repeat (2) @(negedge clk);
        check(done == 1'b0, {cur_tag, " R10 pulse"}, done, 0);
        check(err == 5'(exp_err_g), {cur_tag, " R10 err held"}, err, exp_err_g);
        check(exp_ops.size() == 0, {cur_tag, " ops left"}, exp_ops.size(), 0);
        check(exp_rx.size() == 0, {cur_tag, " rx left"}, exp_rx.size(), 0);
        if (tx_chk_g)
            check(tx_q.size() == 1, {cur_tag, " R9 tx count"}, tx_q.size(), 1);
        exp_ops.delete(); exp_rx.delete(); tx_q.delete();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cmd_ready && !bit_valid && !done && err == 0 && !tx_ready && !rx_valid,
              "reset R10", {cmd_ready, bit_valid, done, tx_ready, rx_valid}, 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        start_txn(10'h02A, 0, 3, 0, -1, -1, 0, 0, 0, 1, "R1 R5 write7"); finish_txn();
        start_txn(10'h051, 0, 0, 1, -1, -1, 0, 0, 0, 1, "R4 read1"); finish_txn();
        start_txn(10'h013, 0, 2, 3, -1, -1, 0, 0, 0, 1, "R3 wr_rd"); finish_txn();
        start_txn(10'h2D6, 1, 2, 0, -1, -1, 0, 0, 0, 1, "R2 ten_write"); finish_txn();
        start_txn(10'h155, 1, 0, 2, -1, -1, 0, 0, 0, 1, "R2 ten_read"); finish_txn();
        start_txn(10'h3FF, 1, 1, 2, -1, -1, 0, 0, 0, 1, "R2 R3 ten_wr_rd"); finish_txn();
        start_txn(10'h07F, 0, 7, 0, -1, -1, 0, 0, 0, 1, "R5 burst_max"); finish_txn();
        start_txn(10'h011, 0, 0, 0, -1, -1, 0, 0, 0, 1, "R5 quick"); finish_txn();
        start_txn(10'h022, 0, 2, 0, 1, -1, 0, 0, 1, 1, "R6 nack_addr"); finish_txn();
        start_txn(10'h022, 0, 2, 1, 3, -1, 0, 0, 1, 1, "R6 nack_data"); finish_txn();
        start_txn(10'h033, 0, 3, 0, -1, 2, 1, 0, 2, 1, "R8 arb"); finish_txn();
        start_txn(10'h033, 0, 0, 2, -1, 0, 0, 0, 4, 1, "R8 bus_err"); finish_txn();
        start_txn(10'h044, 0, 2, 0, -1, -1, 0, 12, 0, 1, "R9 tx_stall"); finish_txn();

        rx_ready = 1'b0;
        start_txn(10'h055, 0, 0, 3, -1, -1, 0, 0, 8, 0, "R11 overrun"); finish_txn();
        rx_ready = 1'b1;
        repeat (3) @(negedge clk);

        wait_limit = 8'd12; bus_busy = 1'b1;
        start_txn(10'h066, 0, 1, 0, -1, -1, 0, 0, 16, 1, "R7 timeout"); finish_txn();

        wait_limit = 8'd200; stop_pending = 1'b1;
        start_txn(10'h067, 0, 1, 0, -1, -1, 0, 0, 0, 1, "R7 late_free");
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (bit_valid) seen = 1'b1;
                if (i == 20) bus_busy = 1'b0;
            end
            check(!seen, "R7 no op while busy", seen, 0);
        end
        stop_pending = 1'b0;
        finish_txn();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule